// File: doc/BRIEF.md
# Cluster Performance Monitor Counter Unit

This block counts hardware events for a shared processor cluster. It holds a parameterised number of 32-bit event counters (up to 31) and one 64-bit cycle counter. Each event counter has a programmable event code. The code picks one bit of a 64-bit event pulse vector, counts every clock cycle, or chains onto the wrap of the counter one slot below it. Software reaches the unit through a simple word-addressed register port. Writes take effect at the clock edge. Reads return data in the same cycle that the read strobe is asserted.

Every per-slot bitmap uses the same slot numbering. Event counter k sits at bit k, and the cycle counter always sits at bit 31. These bitmaps are the counter enables, the overflow interrupt enables and the overflow status. The overflow status is sticky and is cleared by reading it. A single interrupt line is high while an enabled overflow bit is pending.

Register word addresses: 0x00 control, 0x01 counter enables, 0x02 interrupt enables, 0x03 overflow status, 0x04/0x05 supported-code bitmap low/high, 0x06/0x07 cycle counter low/high, 0x20+k event counter k, 0x40+k event code of counter k. Any other address reads 0 and ignores writes.

Top module: `cluster_perf_mon`

## Requirements
- R1: After reset all counters, event codes, enable bitmaps and overflow status are zero, the global enable is clear and `irq` is low.
- R2: Control read layout is: bit 0 global enable, bits 1 and 2 read 0, bit 6 reads 1, bits 3..5 and 7..10 read 0, bits [15:11] give the number of event counters, bits [23:16] the ID code and bits [31:24] the implementer code. A write to bit 0 sets the global enable.
- R3: Event counter k increments by one in a cycle only when the global enable, enable bit k and event input bit `evtIn[code]` are all 1. Its code is the low 6 bits of its code register.
- R4: Code 0x11 makes an event counter count every enabled cycle. Code 0x1E makes it increment in the cycle in which counter k-1 wraps, and a chain code on counter 0 never counts.
- R5: The cycle counter is 64 bits wide and is read or written as two 32-bit halves. It increments every cycle in which the global enable and enable bit 31 are both 1.
- R6: A counter passing its all-ones value wraps to zero and sets the overflow status bit of its slot (bit k, or bit 31 for the cycle counter).
- R7: Reading the overflow status returns the pending bits and clears them in the same access. A wrap that occurs in that same cycle stays pending.
- R8: `irq` is high exactly while some overflow status bit and its interrupt enable bit are both 1.
- R9: Writing control with bit 1 set zeroes all event counters, and writing it with bit 2 set zeroes the cycle counter. Either clear overrides counting in that cycle.
- R10: A write to a counter register loads the written value, and this overrides any increment in that cycle.
- R11: Addresses 0x04 and 0x05 return the low and high halves of the 64-bit supported-code parameter and ignore writes.
- R12: Enable and interrupt-enable bits of unimplemented slots ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (needed for the overflow clear-on-read) |
| addr | input | 7 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, valid in the same cycle |
| evtIn | input | 64 | Event pulses, one bit per event code |
| irq | output | 1 | Overflow interrupt |

## Verification
Several properties are checked on every cycle. An idle event counter holds its value. The cycle counter steps by exactly one while counting. A clear leaves every event counter at zero. Overflow bits never vanish without a status read, and none appear while the global enable is off.

Other behaviour needs the bench's scenarios and its reference model. This covers chained counting across a wrap, the priority of writes and clears over increments, and the clear-on-read racing a new wrap. It also covers the interrupt following enable changes and the exact control-register layout.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CODE_W    = 6;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int SLOT_W    = 5;
  localparam int CYC_SLOT  = 31;

  localparam logic [CODE_W-1:0] CODE_CYCLES = 6'h11;
  localparam logic [CODE_W-1:0] CODE_CHAIN  = 6'h1E;

  localparam logic [6:0] A_CTRL  = 7'h00;
  localparam logic [6:0] A_CNTEN = 7'h01;
  localparam logic [6:0] A_INTEN = 7'h02;
  localparam logic [6:0] A_OVF   = 7'h03;
  localparam logic [6:0] A_SUPLO = 7'h04;
  localparam logic [6:0] A_SUPHI = 7'h05;
  localparam logic [6:0] A_CYCLO = 7'h06;
  localparam logic [6:0] A_CYCHI = 7'h07;
  localparam logic [1:0] PG_CNT  = 2'b01;
  localparam logic [1:0] PG_SEL  = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic              clrEvt;
    logic              clrCyc;
    logic              wrEvt;
    logic              wrSel;
    logic              wrCycLo;
    logic              wrCycHi;
    logic [SLOT_W-1:0] wrIdx;
    logic [31:0]       wdata;
    logic [31:0]       cntEn;
  } pmu_strb_t;
endpackage

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pmu_strb_t                     strb,
  input  logic [NUM_CODES-1:0]          evtIn,
  output logic [NUM_EVT-1:0][31:0]      cntVal,
  output logic [NUM_EVT-1:0][CODE_W-1:0] evtType,
  output logic [63:0]                   cycVal,
  output logic [31:0]                   wrapVec
);
  logic [31:0]       cnt [NUM_EVT];
  logic [CODE_W-1:0] typ [NUM_EVT];
  logic              incEvt  [NUM_EVT];
  logic              wrapEvt [NUM_EVT];
  logic              wrHit   [NUM_EVT];
  logic [63:0]       cyc;
  logic              cycWrap;
  logic              cycLoad;

  // increment and wrap decisions, chained from low slot to high slot
  always_comb begin
    for (int i = 0; i < NUM_EVT; i++) begin
      logic hit;
      wrHit[i] = strb.wrEvt && (strb.wrIdx == SLOT_W'(i));
      if (typ[i] == CODE_CYCLES)     hit = 1'b1;
      else if (typ[i] == CODE_CHAIN) hit = 1'b0;
      else                           hit = evtIn[typ[i]];
      if (typ[i] == CODE_CHAIN && i > 0) hit = wrapEvt[i-1];
      incEvt[i]  = strb.cntEn[i] && hit && !wrHit[i] && !strb.clrEvt;
      wrapEvt[i] = incEvt[i] && (cnt[i] == 32'hFFFF_FFFF);
    end
  end

  assign cycLoad = strb.clrCyc || strb.wrCycLo || strb.wrCycHi;
  assign cycWrap = strb.cntEn[CYC_SLOT] && !cycLoad && (cyc == 64'hFFFF_FFFF_FFFF_FFFF);

  always_comb begin
    wrapVec = '0;
    for (int i = 0; i < NUM_EVT; i++) wrapVec[i] = wrapEvt[i];
    wrapVec[CYC_SLOT] = cycWrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_EVT; i++) begin
        cnt[i] <= '0;
        typ[i] <= '0;
      end
      cyc <= '0;
    end else begin
      for (int i = 0; i < NUM_EVT; i++) begin
        if (strb.clrEvt)    cnt[i] <= '0;
        else if (wrHit[i])  cnt[i] <= strb.wdata;
        else if (incEvt[i]) cnt[i] <= cnt[i] + 32'd1;
        if (strb.wrSel && strb.wrIdx == SLOT_W'(i)) typ[i] <= strb.wdata[CODE_W-1:0];
      end
      if (strb.clrCyc)                  cyc <= '0;
      else if (strb.wrCycLo)            cyc <= {cyc[63:32], strb.wdata};
      else if (strb.wrCycHi)            cyc <= {strb.wdata, cyc[31:0]};
      else if (strb.cntEn[CYC_SLOT])    cyc <= cyc + 64'd1;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_EVT; i++) begin
      cntVal[i]  = cnt[i];
      evtType[i] = typ[i];
    end
  end
  assign cycVal = cyc;

  // ---------------- assertions ----------------
  logic evtAllZero;
  always_comb begin
    evtAllZero = 1'b1;
    for (int i = 0; i < NUM_EVT; i++) if (cnt[i] != 32'd0) evtAllZero = 1'b0;
  end

  a_r5_cyc_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntEn[CYC_SLOT] && !cycLoad) |=> (cyc == $past(cyc) + 64'd1));

  a_r9_evt_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrEvt |=> evtAllZero);

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_hold
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.cntEn[g] && !strb.clrEvt && !(strb.wrEvt && strb.wrIdx == SLOT_W'(g)))
      |=> $stable(cnt[g]));
  end
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
#(
  parameter int          NUM_EVT  = 4,
  parameter logic [7:0]  ID_CODE  = 8'h2A,
  parameter logic [7:0]  IMP_CODE = 8'h41,
  parameter logic [63:0] SUPPORT  = 64'h0000_0000_7E02_0001
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic                           rdEn,
  input  logic [6:0]                     addr,
  input  logic [31:0]                    wdata,
  output logic [31:0]                    rdata,
  output logic                           irq,
  output pmu_strb_t                      strb,
  input  logic [NUM_EVT-1:0][31:0]       cntVal,
  input  logic [NUM_EVT-1:0][CODE_W-1:0] evtType,
  input  logic [63:0]                    cycVal,
  input  logic [31:0]                    wrapVec
);
  localparam logic [31:0] SLOT_MASK = 32'h8000_0000 | ((32'd1 << NUM_EVT) - 32'd1);
  localparam logic [10:0] CTRL_RSV  = 11'h040;

  logic        gEn;
  logic [31:0] cntEnR, intEnR, ovf;
  logic        isCnt, isSel, idxOk, rdOvf;
  logic [SLOT_W-1:0] idx;

  assign idx   = addr[SLOT_W-1:0];
  assign isCnt = (addr[6:5] == PG_CNT);
  assign isSel = (addr[6:5] == PG_SEL);
  assign idxOk = (idx < SLOT_W'(NUM_EVT));
  assign rdOvf = rdEn && (addr == A_OVF);

  always_comb begin
    strb.clrEvt  = wrEn && (addr == A_CTRL) && wdata[1];
    strb.clrCyc  = wrEn && (addr == A_CTRL) && wdata[2];
    strb.wrEvt   = wrEn && isCnt && idxOk;
    strb.wrSel   = wrEn && isSel && idxOk;
    strb.wrCycLo = wrEn && (addr == A_CYCLO);
    strb.wrCycHi = wrEn && (addr == A_CYCHI);
    strb.wrIdx   = idx;
    strb.wdata   = wdata;
    strb.cntEn   = gEn ? cntEnR : 32'd0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gEn    <= 1'b0;
      cntEnR <= '0;
      intEnR <= '0;
      ovf    <= '0;
    end else begin
      if (wrEn && addr == A_CTRL)  gEn    <= wdata[0];
      if (wrEn && addr == A_CNTEN) cntEnR <= wdata & SLOT_MASK;
      if (wrEn && addr == A_INTEN) intEnR <= wdata & SLOT_MASK;
      ovf <= (rdOvf ? 32'd0 : ovf) | wrapVec;
    end
  end

  assign irq = |(ovf & intEnR);

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = {IMP_CODE, ID_CODE, SLOT_W'(NUM_EVT), CTRL_RSV | {10'd0, gEn}};
      A_CNTEN: rdata = cntEnR;
      A_INTEN: rdata = intEnR;
      A_OVF:   rdata = ovf;
      A_SUPLO: rdata = SUPPORT[31:0];
      A_SUPHI: rdata = SUPPORT[63:32];
      A_CYCLO: rdata = cycVal[31:0];
      A_CYCHI: rdata = cycVal[63:32];
      default: begin
        for (int i = 0; i < NUM_EVT; i++) begin
          if (idx == SLOT_W'(i) && isCnt) rdata = cntVal[i];
          if (idx == SLOT_W'(i) && isSel) rdata = {{(32-CODE_W){1'b0}}, evtType[i]};
        end
      end
    endcase
  end

  // ---------------- assertions ----------------
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !rdOvf |=> ((ovf & $past(ovf)) == $past(ovf)));

  a_r6_no_wrap_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !gEn |=> ((ovf & ~$past(ovf)) == 32'd0));

  a_r12_unimpl_slots: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ((ovf & intEnR & ~SLOT_MASK) == 32'd0));
endmodule

// File: rtl/cluster_perf_mon.sv
module cluster_perf_mon
  import pmu_pkg::*;
#(
  parameter int          NUM_EVT  = 4,
  parameter logic [7:0]  ID_CODE  = 8'h2A,
  parameter logic [7:0]  IMP_CODE = 8'h41,
  parameter logic [63:0] SUPPORT  = 64'h0000_0000_7E02_0001
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [6:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [63:0] evtIn,
  output logic        irq
);
  pmu_strb_t                      strb;
  logic [NUM_EVT-1:0][31:0]       cntVal;
  logic [NUM_EVT-1:0][CODE_W-1:0] evtType;
  logic [63:0]                    cycVal;
  logic [31:0]                    wrapVec;

  pmu_ctrl #(.NUM_EVT(NUM_EVT), .ID_CODE(ID_CODE), .IMP_CODE(IMP_CODE), .SUPPORT(SUPPORT)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .strb(strb), .cntVal(cntVal), .evtType(evtType),
    .cycVal(cycVal), .wrapVec(wrapVec));

  pmu_datapath #(.NUM_EVT(NUM_EVT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evtIn(evtIn), .cntVal(cntVal),
    .evtType(evtType), .cycVal(cycVal), .wrapVec(wrapVec));
endmodule

// File: tb/sim_cluster_perf_mon.sv
`timescale 1ns/1ps
module sim_cluster_perf_mon;
  localparam int          N    = 4;
  localparam logic [63:0] SUP  = 64'h0000_0000_7E02_0001;
  localparam logic [31:0] MASK = 32'h8000_0000 | ((32'd1 << N) - 32'd1);

  logic clk = 0, rstN = 0, wrEn = 0, rdEn = 0, irq;
  logic [6:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [63:0] evtIn = 0;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  cluster_perf_mon #(.NUM_EVT(N), .ID_CODE(8'h2A), .IMP_CODE(8'h41), .SUPPORT(SUP)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evtIn(evtIn), .irq(irq));

  // reference model
  logic [31:0] mCnt [N];
  logic [5:0]  mTyp [N];
  logic [63:0] mCyc;
  logic [31:0] mEn, mIen, mOvf;
  logic        mE;

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin mCnt[i] = 0; mTyp[i] = 0; end
    mCyc = 0; mEn = 0; mIen = 0; mOvf = 0; mE = 0;
  endtask

  function automatic logic [31:0] expRd(input logic [6:0] a);
    logic [31:0] v = 0;
    case (a)
      7'h00: v = {8'h41, 8'h2A, 5'(N), 11'h040 | {10'd0, mE}};
      7'h01: v = mEn;
      7'h02: v = mIen;
      7'h03: v = mOvf;
      7'h04: v = SUP[31:0];
      7'h05: v = SUP[63:32];
      7'h06: v = mCyc[31:0];
      7'h07: v = mCyc[63:32];
      default: for (int i = 0; i < N; i++) begin
        if (a == {2'b01, 5'(i)}) v = mCnt[i];
        if (a == {2'b10, 5'(i)}) v = {26'd0, mTyp[i]};
      end
    endcase
    return v;
  endfunction

  task automatic model_step(input logic we, input logic re, input logic [6:0] a,
                            input logic [31:0] wd, input logic [63:0] ev);
    logic [31:0] wr = 0;
    logic clrE = we && a == 7'h00 && wd[1];
    logic clrC = we && a == 7'h00 && wd[2];
    for (int i = 0; i < N; i++) begin
      logic isW = we && a == {2'b01, 5'(i)};
      logic hit;
      if (mTyp[i] == 6'h11) hit = 1;
      else if (mTyp[i] == 6'h1E) hit = (i > 0) ? wr[i-1] : 1'b0;
      else hit = ev[mTyp[i]];
      if (clrE) mCnt[i] = 0;
      else if (isW) mCnt[i] = wd;
      else if (mE && mEn[i] && hit) begin
        if (mCnt[i] == 32'hFFFF_FFFF) wr[i] = 1;
        mCnt[i] = mCnt[i] + 1;
      end
    end
    if (clrC) mCyc = 0;
    else if (we && a == 7'h06) mCyc[31:0] = wd;
    else if (we && a == 7'h07) mCyc[63:32] = wd;
    else if (mE && mEn[31]) begin
      if (mCyc == 64'hFFFF_FFFF_FFFF_FFFF) wr[31] = 1;
      mCyc = mCyc + 1;
    end
    for (int i = 0; i < N; i++) if (we && a == {2'b10, 5'(i)}) mTyp[i] = wd[5:0];
    mOvf = ((re && a == 7'h03) ? 32'd0 : mOvf) | wr;
    if (we && a == 7'h00) mE = wd[0];
    if (we && a == 7'h01) mEn = wd & MASK;
    if (we && a == 7'h02) mIen = wd & MASK;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive after falling edge, check, advance model, wait rising edge
  task automatic cyc(input string tag, input logic we, input logic re, input logic [6:0] a,
                     input logic [31:0] wd, input logic [63:0] ev);
    @(negedge clk);
    wrEn = we; rdEn = re; addr = a; wdata = wd; evtIn = ev;
    #1;
    if (re) chk(tag, rdata, expRd(a));
    chk("R8 irq", {31'd0, irq}, {31'd0, |(mOvf & mIen)});
    model_step(we, re, a, wd, ev);
    @(posedge clk);
  endtask

  task automatic wr(input string tag, input logic [6:0] a, input logic [31:0] d);
    cyc(tag, 1, 0, a, d, 0);
  endtask
  task automatic rd(input string tag, input logic [6:0] a);
    cyc(tag, 0, 1, a, 0, 0);
  endtask
  task automatic ev(input string tag, input logic [63:0] e);
    cyc(tag, 0, 0, 0, 0, e);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1 reset state, R2 control layout
    rd("R2 ctrl layout", 7'h00);
    rd("R1 enables", 7'h01); rd("R1 ovf", 7'h03); rd("R1 cnt0", 7'h20); rd("R1 cyc", 7'h06);
    rd("R1 type0", 7'h40);
    // R11 supported codes, write ignored
    wr("R11 write", 7'h04, 32'hDEAD_BEEF);
    rd("R11 lo", 7'h04); rd("R11 hi", 7'h05);
    // R12 unimplemented slots
    wr("R12 en", 7'h01, 32'hFFFF_FFFF); rd("R12 en read", 7'h01);
    wr("R12 ien", 7'h02, 32'h7FFF_0000); rd("R12 ien read", 7'h02);
    wr("R12 ien", 7'h02, 32'h0);
    // R3 gating by global enable and event input
    wr("R3 sel0", 7'h40, 32'd5); wr("R4 sel1", 7'h41, 32'h11); wr("R4 sel2", 7'h42, 32'h1E);
    wr("R3 en", 7'h01, 32'h0000_0007);
    ev("R3 off", 64'h20); rd("R3 gated off", 7'h20);
    wr("R2 enable", 7'h00, 32'h1); rd("R2 E readback", 7'h00);
    ev("R3 hit", 64'h20); ev("R3 miss", 64'h10); ev("R3 hit", 64'h21);
    rd("R3 cnt0", 7'h20); rd("R4 cycles code", 7'h21);
    // R6 / R4 chain wrap
    wr("R10 load", 7'h20, 32'hFFFF_FFFF);
    ev("R6 wrap", 64'h20);
    rd("R6 cnt0 zero", 7'h20); rd("R4 chain", 7'h22);
    // R7 read clears; R8 irq
    wr("R8 ien", 7'h02, 32'h1);
    ev("R8 idle", 0);
    rd("R7 ovf read", 7'h03); rd("R7 ovf cleared", 7'h03);
    // R7 wrap in same cycle as read stays pending
    wr("R10 load", 7'h20, 32'hFFFF_FFFF);
    cyc("R7 race", 0, 1, 7'h03, 0, 64'h20);
    rd("R7 race pending", 7'h03);
    // R10 write beats count
    cyc("R10 write vs count", 1, 0, 7'h20, 32'h1234_5678, 64'h20);
    rd("R10 cnt0", 7'h20);
    // R5 cycle counter 64-bit
    wr("R5 lo", 7'h06, 32'hFFFF_FFFE); wr("R5 hi", 7'h07, 32'hFFFF_FFFF);
    wr("R5 en", 7'h01, 32'h8000_0007); wr("R8 ien31", 7'h02, 32'h8000_0000);
    ev("R5 tick", 0); ev("R5 tick", 0); ev("R5 tick", 0);
    rd("R5 lo", 7'h06); rd("R5 hi", 7'h07); rd("R6 cyc ovf", 7'h03);
    // R9 clears
    wr("R9 P", 7'h00, 32'h3); rd("R9 evt zero", 7'h21); rd("R9 PC read 0", 7'h00);
    wr("R9 C", 7'h00, 32'h5); rd("R9 cyc zero", 7'h06);
    // random mix
    for (int k = 0; k < 4000; k++) begin
      int op = $urandom % 10;
      logic [6:0] a;
      logic [31:0] d = $urandom;
      logic [63:0] e = {$urandom, $urandom};
      case ($urandom % 6)
        0: a = 7'h00; 1: a = 7'h01; 2: a = 7'h02; 3: a = 7'h03;
        4: a = 7'h06 + 7'($urandom % 2);
        default: a = {($urandom % 2) ? 2'b01 : 2'b10, 5'($urandom % (N + 1))};
      endcase
      if (a == 7'h00) d = {29'd0, 3'($urandom % 8) | 3'd1} & (($urandom % 8 == 0) ? 32'h7 : 32'h1);
      if (a[6:5] == 2'b01 && ($urandom % 2)) d = 32'hFFFF_FFF0 | 32'($urandom % 16);
      if (a[6:5] == 2'b10) d = ($urandom % 2) ? 32'h1E : 32'($urandom % 64);
      if (op < 2)      cyc("R10 rand write", 1, 0, a, d, e);
      else if (op < 5) cyc("R3 rand read", 0, 1, a, 0, e);
      else             cyc("R3 rand count", 0, 0, 0, 0, e);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule